// File: doc/BRIEF.md
# Windowed Tone Frequency Qualifier

This block decides whether a digital tone has held a programmed frequency for long enough. The tone input passes through a synchronizer, and its rising edges are counted over back-to-back sample windows. Each window lasts half a second of the system clock, which is 16,384 cycles at 32,768 Hz. A window either passes or fails. It passes when its edge count lies within a tolerance of the count the target frequency should produce.

The first passing window raises a valid-frequency flag. The block then counts consecutive passing windows, and the first passing window counts toward that total. When the programmed number is reached, the block emits one fixed-length timeout pulse. A single failing window drops the flag and restarts the count, so the tone must persist without a break. Separate rising-edge requests switch the qualifier off and on. A synchronous reset returns the block to its enabled, idle state. The target frequency, the window length, the tolerance, the interval length in windows and the pulse length are all parameters.

Top module: `tone_qualifier`

## Requirements
- R1: After reset, `freq_ok` and `interval_done` are 0 and `qual_enabled` is 1.
- R2: `tone_in` passes through a two-flop synchronizer. Its synchronized rising edges are counted over windows of `WIN_CYC` clock cycles. The first window begins on the first clock after `qual_enabled` has become 1.
- R3: A window passes when its edge count N satisfies |N − NOM| ≤ `TOL_EDGES`, where NOM = `TARGET_HZ`·`WIN_CYC`/`CLK_HZ` (integer division). Any other count fails.
- R4: `freq_ok` becomes 1 at the clock edge that closes a passing window. It stays 1 while every following window passes.
- R5: At the edge that closes a failing window, `freq_ok` becomes 0 and the count of consecutive passing windows restarts at zero.
- R6: At the edge that closes the `INTERVAL_WIN`-th consecutive passing window, `interval_done` goes high for exactly `PULSE_CYC` cycles.
- R7: `interval_done` fires once for each qualified tone. It can fire again only after a failing window or a disable.
- R8: A rising edge on `off_req` clears `qual_enabled`, `freq_ok`, `interval_done` and all window and interval state at the next clock edge.
- R9: A rising edge on `on_req` sets `qual_enabled`. A level held high does not act again. When both requests rise in the same cycle, the disable wins.
- R10: While `qual_enabled` is 0, `tone_in` has no effect: `freq_ok` and `interval_done` stay 0.
- R11: `rst` high at a clock edge clears all state and sets `qual_enabled`, whatever the block's state was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (32,768 Hz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| tone_in | input | 1 | Digital tone, asynchronous to `clk` |
| on_req | input | 1 | Enable request, acts on its rising edge |
| off_req | input | 1 | Disable request, acts on its rising edge |
| qual_enabled | output | 1 | Qualifier enable flag |
| freq_ok | output | 1 | Last window passed and the run is unbroken |
| interval_done | output | 1 | Timeout pulse after the full interval |

## Verification
The properties assume that `on_req` and `off_req` are synchronous to `clk`, that `PULSE_CYC` is shorter than a window, and that `WIN_CYC` is at least 2. Only `tone_in` may change without regard to the clock. The bench drives every input on the falling edge. It produces the tone from a generator whose period is a whole number of clock cycles. It uses short windows, so that counts just inside and just outside both ends of the pass band can each be reached within a few windows.

// File: rtl/tq_pkg.sv
package tq_pkg;

    // Result of one closed sample window, valid in the cycle it closes.
    typedef struct packed {
        logic done;
        logic pass;
    } win_res_t;

    // Decoded request from the enable / disable inputs.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } arm_cmd_e;

    // Edges expected in one window for the target frequency.
    function automatic int unsigned nominal_edges(input int unsigned hz,
                                                  input int unsigned win,
                                                  input int unsigned clk_hz);
        return (hz * win) / clk_hz;
    endfunction

    // Count lies within nom +/- tol, both ends inclusive.
    function automatic logic in_band(input int unsigned cnt,
                                     input int unsigned nom,
                                     input int unsigned tol);
        return ((cnt + tol) >= nom) && (cnt <= (nom + tol));
    endfunction

endpackage

// File: rtl/tq_edge_sync.sv
module tq_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tq_arm.sv
module tq_arm
    import tq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    output logic enabled,
    output logic run
);
    logic     on_q;
    logic     off_q;
    arm_cmd_e cmd;

    // History flops follow the inputs even in reset, so a level held
    // across reset is not taken as a fresh edge.
    always_ff @(posedge clk) begin
        on_q  <= on_req;
        off_q <= off_req;
    end

    always_comb begin
        cmd = CMD_NONE;
        if (off_req && !off_q) begin
            cmd = CMD_OFF;
        end else if (on_req && !on_q) begin
            cmd = CMD_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b1;
        end else begin
            case (cmd)
                CMD_OFF: enabled <= 1'b0;
                CMD_ON:  enabled <= 1'b1;
                default: enabled <= enabled;
            endcase
        end
    end

    // Qualifier runs only while enabled and not being switched off now.
    assign run = enabled && (cmd != CMD_OFF);
endmodule

// File: rtl/tq_window.sv
module tq_window
    import tq_pkg::*;
#(
    parameter int unsigned WIN_CYC   = 16384,
    parameter int unsigned NOM       = 1356,
    parameter int unsigned TOL_EDGES = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     tone_edge,
    output win_res_t res
);
    localparam int unsigned WW = $clog2(WIN_CYC);
    localparam int unsigned EW = $clog2(WIN_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

    logic [WW-1:0] wcnt;
    logic [EW-1:0] ecnt;
    logic [EW:0]   total;
    logic          last_cyc;

    assign last_cyc = (wcnt == LAST);
    assign total    = {1'b0, ecnt} + (EW+1)'(tone_edge);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            wcnt <= '0;
            ecnt <= '0;
        end else if (last_cyc) begin
            wcnt <= '0;
            ecnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
            ecnt <= ecnt + EW'(tone_edge);
        end
    end

    // The edge seen in the closing cycle still belongs to this window.
    always_comb begin
        res.done = run && last_cyc;
        res.pass = in_band(32'(total), NOM, TOL_EDGES);
    end
endmodule

// File: rtl/tq_interval.sv
module tq_interval
    import tq_pkg::*;
#(
    parameter int unsigned INTERVAL_WIN = 9,
    parameter int unsigned PULSE_CYC    = 4096
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  win_res_t res,
    output logic     valid,
    output logic     pulse
);
    localparam int unsigned IW = $clog2(INTERVAL_WIN + 1);
    localparam int unsigned PW = $clog2(PULSE_CYC + 1);
    localparam logic [IW-1:0] GOAL_M1 = IW'(INTERVAL_WIN - 1);

    logic [IW-1:0] good_cnt;
    logic [PW-1:0] pcnt;
    logic          fired;
    logic          fire;

    assign fire = res.done && res.pass && !fired && (good_cnt == GOAL_M1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            valid    <= 1'b0;
            good_cnt <= '0;
            fired    <= 1'b0;
        end else if (res.done) begin
            if (res.pass) begin
                valid <= 1'b1;
                if (!fired) begin
                    good_cnt <= good_cnt + 1'b1;
                    fired    <= fire;
                end
            end else begin
                valid    <= 1'b0;
                good_cnt <= '0;
                fired    <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (fire) begin
            pcnt <= PW'(PULSE_CYC);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    assign pulse = (pcnt != '0);
endmodule

// File: rtl/tone_qualifier.sv
module tone_qualifier
    import tq_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 32768,
    parameter int unsigned TARGET_HZ    = 2713,
    parameter int unsigned WIN_CYC      = CLK_HZ / 2,
    parameter int unsigned TOL_EDGES    = 5,
    parameter int unsigned INTERVAL_WIN = 9,
    parameter int unsigned PULSE_CYC    = 4096,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tone_in,
    input  logic on_req,
    input  logic off_req,
    output logic qual_enabled,
    output logic freq_ok,
    output logic interval_done
);
    localparam int unsigned NOM = nominal_edges(TARGET_HZ, WIN_CYC, CLK_HZ);

    logic     tone_edge;
    logic     run;
    win_res_t win_res;

    tq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (tone_in),
        .rise     (tone_edge)
    );

    tq_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .on_req  (on_req),
        .off_req (off_req),
        .enabled (qual_enabled),
        .run     (run)
    );

    tq_window #(
        .WIN_CYC   (WIN_CYC),
        .NOM       (NOM),
        .TOL_EDGES (TOL_EDGES)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .tone_edge (tone_edge),
        .res       (win_res)
    );

    tq_interval #(
        .INTERVAL_WIN (INTERVAL_WIN),
        .PULSE_CYC    (PULSE_CYC)
    ) u_ivl (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .res   (win_res),
        .valid (freq_ok),
        .pulse (interval_done)
    );
endmodule

// File: rtl/tq_checker.sv
module tq_checker
    import tq_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4096
) (
    input logic     clk,
    input logic     rst,
    input logic     on_req,
    input logic     off_req,
    input logic     qual_enabled,
    input logic     freq_ok,
    input logic     interval_done,
    input win_res_t win_res
);
    int   pw_cnt;
    logic pulse_q;
    logic fired_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_cnt     <= 0;
            pulse_q    <= 1'b0;
            fired_seen <= 1'b0;
        end else begin
            pw_cnt     <= interval_done ? pw_cnt + 1 : 0;
            pulse_q    <= interval_done;
            fired_seen <= fired_seen ? (freq_ok && qual_enabled)
                                     : (interval_done && !pulse_q);
        end
    end

    a_r4_rise_on_pass: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_ok) |-> $past(win_res.done && win_res.pass));

    a_r5_fail_drops: assert property (@(posedge clk) disable iff (rst)
        (win_res.done && !win_res.pass) |=> !freq_ok);

    a_r6_pulse_len: assert property (@(posedge clk) disable iff (rst)
        interval_done |-> (pw_cnt < int'(PULSE_CYC)));

    a_r6_pulse_full: assert property (@(posedge clk) disable iff (rst)
        ($fell(interval_done) && qual_enabled) |-> (pw_cnt == int'(PULSE_CYC)));

    a_r6_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(interval_done) |-> freq_ok);

    a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
        $rose(interval_done) |-> !fired_seen);

    a_r8_off_clears: assert property (@(posedge clk) disable iff (rst)
        (off_req && !$past(off_req)) |=> (!qual_enabled && !freq_ok && !interval_done));

    a_r9_on_sets: assert property (@(posedge clk) disable iff (rst)
        (on_req && !$past(on_req) && !(off_req && !$past(off_req))) |=> qual_enabled);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !qual_enabled |-> (!freq_ok && !interval_done));
endmodule

bind tone_qualifier tq_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .on_req        (on_req),
    .off_req       (off_req),
    .qual_enabled  (qual_enabled),
    .freq_ok       (freq_ok),
    .interval_done (interval_done),
    .win_res       (win_res)
);

// File: tb/sim_tone_qualifier.sv
`timescale 1ns/1ps
module sim_tone_qualifier;
    localparam int CLK_HZ = 32768;
    localparam int TGT    = 2048;
    localparam int W      = 1024;
    localparam int TOL    = 5;
    localparam int IV     = 3;
    localparam int PL     = 256;
    localparam int NOM    = TGT * W / CLK_HZ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tone = 1'b0;
    logic on_r = 1'b0;
    logic off_r = 1'b0;
    logic en_o, ok_o, done_o;

    int n_chk = 0;
    int n_fail = 0;
    int period = 0;
    int ph = 0;
    int rises = 0;
    logic done_q = 1'b0;
    bit finished = 0;

    always #4 clk = ~clk;

    tone_qualifier #(
        .CLK_HZ(CLK_HZ), .TARGET_HZ(TGT), .WIN_CYC(W), .TOL_EDGES(TOL),
        .INTERVAL_WIN(IV), .PULSE_CYC(PL), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst(rst), .tone_in(tone), .on_req(on_r), .off_req(off_r),
        .qual_enabled(en_o), .freq_ok(ok_o), .interval_done(done_o)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tone generator, period in clock cycles (0 = silent).
    always @(negedge clk) begin
        if (period == 0) begin
            tone <= 1'b0;
            ph   <= 0;
        end else begin
            tone <= (ph < period / 2);
            ph   <= (ph + 1 >= period) ? 0 : ph + 1;
        end
    end

    // Behavioural reference model.
    int  m_s1, m_s2, m_s3, m_w, m_e, m_iv, m_p;
    bit  m_arm, m_valid, m_fired, m_on_p, m_off_p, started;
    initial begin
        m_on_p = 0; m_off_p = 0; started = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0; m_w = 0; m_e = 0; m_iv = 0; m_p = 0;
        m_arm = 1; m_valid = 0; m_fired = 0;
    end

    always @(posedge clk) begin
        bit on_rise, off_rise, run, edge_now, pass;
        int tot;
        on_rise  = on_r && !m_on_p;
        off_rise = off_r && !m_off_p;
        m_on_p   = on_r;
        m_off_p  = off_r;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_w = 0; m_e = 0; m_iv = 0; m_p = 0;
            m_arm = 1; m_valid = 0; m_fired = 0;
            started = 1;
        end else begin
            edge_now = (m_s2 == 1) && (m_s3 == 0);
            run = m_arm && !off_rise;
            if (!run) begin
                m_w = 0; m_e = 0; m_valid = 0; m_iv = 0; m_fired = 0; m_p = 0;
            end else begin
                if (m_p > 0) m_p--;
                if (m_w == W - 1) begin
                    tot  = m_e + int'(edge_now);
                    pass = (tot >= NOM - TOL) && (tot <= NOM + TOL);
                    m_w = 0; m_e = 0;
                    if (pass) begin
                        m_valid = 1;
                        if (!m_fired) begin
                            m_iv++;
                            if (m_iv == IV) begin
                                m_fired = 1;
                                m_p = PL;
                            end
                        end
                    end else begin
                        m_valid = 0; m_iv = 0; m_fired = 0;
                    end
                end else begin
                    m_w++;
                    m_e += int'(edge_now);
                end
            end
            if (off_rise) m_arm = 0;
            else if (on_rise) m_arm = 1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(tone);
        end
    end

    // Lock-step comparison and pulse counting, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(en_o == m_arm, "R9 qual_enabled vs model", int'(en_o), int'(m_arm));
            chk(ok_o == m_valid, "R4 R5 freq_ok vs model", int'(ok_o), int'(m_valid));
            chk(done_o == (m_p > 0), "R6 interval_done vs model", int'(done_o), int'(m_p > 0));
        end
        if (done_o && !done_q) rises++;
        done_q <= done_o;
    end

    task automatic wait_win(input int k);
        repeat (k * W) @(negedge clk);
    endtask

    task automatic pulse_off();
        off_r = 1'b1;
        @(negedge clk);
        chk(en_o == 1'b0 && ok_o == 1'b0 && done_o == 1'b0, "R8 off clears", int'(en_o), 0);
        repeat (2) @(negedge clk);
        off_r = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(ok_o == 1'b0 && done_o == 1'b0, "R1 reset outputs low", int'(ok_o), 0);
        chk(en_o == 1'b1, "R11 reset sets enable", int'(en_o), 1);
        rst = 1'b0;

        // R2 R4 R6: steady in-band tone (64 edges per window)
        period = 16;
        wait_win(5);
        chk(ok_o == 1'b1, "R4 valid after passing windows", int'(ok_o), 1);
        chk(rises == 1, "R6 one timeout pulse", rises, 1);
        wait_win(3);
        chk(rises == 1, "R7 no refire while tone holds", rises, 1);

        // R5: far out-of-band tone
        period = 20;
        wait_win(2);
        chk(ok_o == 1'b0, "R5 failing window drops valid", int'(ok_o), 0);

        // R3: just below the band (about 57 edges)
        period = 18;
        wait_win(2);
        chk(ok_o == 1'b0, "R3 below band fails", int'(ok_o), 0);

        // R3: upper side inside the band (about 68 edges)
        period = 15;
        wait_win(2);
        chk(ok_o == 1'b1, "R3 upper side in band", int'(ok_o), 1);
        chk(rises == 1, "R5 interval restarted after fail", rises, 1);
        wait_win(2);
        chk(rises == 2, "R7 refires after fail", rises, 2);

        // R3: lower side inside the band (about 60 edges)
        period = 17;
        wait_win(2);
        chk(ok_o == 1'b1, "R3 lower side in band", int'(ok_o), 1);

        // R3: just above the band (about 73 edges)
        period = 14;
        wait_win(2);
        chk(ok_o == 1'b0, "R3 above band fails", int'(ok_o), 0);

        // R8 R10: disable, then a good tone is ignored
        period = 16;
        pulse_off();
        base = rises;
        wait_win(4);
        chk(ok_o == 1'b0 && en_o == 1'b0, "R10 tone ignored while off", int'(ok_o), 0);
        chk(rises == base, "R10 no pulse while off", rises, base);

        // R9 R2: enable, qualification restarts cleanly
        on_r = 1'b1;
        repeat (2) @(negedge clk);
        chk(en_o == 1'b1, "R9 on edge enables", int'(en_o), 1);
        wait_win(4);
        chk(ok_o == 1'b1, "R2 windows restart after enable", int'(ok_o), 1);
        chk(rises == base + 1, "R6 pulse after re-enable", rises, base + 1);

        // R9: held on level does not re-enable after an off edge
        pulse_off();
        repeat (20) @(negedge clk);
        chk(en_o == 1'b0, "R9 held on level ignored", int'(en_o), 0);

        // R9: both rise together, disable wins
        on_r = 1'b0;
        @(negedge clk);
        on_r = 1'b1;
        @(negedge clk);
        chk(en_o == 1'b1, "R9 fresh on edge enables", int'(en_o), 1);
        on_r = 1'b0;
        repeat (2) @(negedge clk);
        on_r = 1'b1;
        off_r = 1'b1;
        @(negedge clk);
        chk(en_o == 1'b0, "R9 simultaneous edges disable", int'(en_o), 0);
        on_r = 1'b0;
        off_r = 1'b0;
        @(negedge clk);

        // R11: reset re-enables and clears mid-run
        rst = 1'b1;
        @(negedge clk);
        chk(en_o == 1'b1 && ok_o == 1'b0, "R11 reset from disabled", int'(en_o), 1);
        rst = 1'b0;
        wait_win(2);
        chk(ok_o == 1'b1, "R4 valid after reset", int'(ok_o), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(ok_o == 1'b0 && done_o == 1'b0, "R11 reset clears valid", int'(ok_o), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        finish_run();
    end
endmodule